// File: doc/BRIEF.md
# Signal-Processor Output Shifter and Latch Update

This block sits at the back end of one step of a sample-processing datapath. It takes the multiply-accumulate result and holds it for one step in a register. On the next step it scales that held value into a 24-bit word. Four scaling modes are available. Two of them clamp at the 24-bit signed limits and two of them wrap silently.

The scaled word then feeds several destinations, each gated by a flag in the current instruction:
- a temporary-RAM write port, whose address is an instruction offset plus a ring counter, wrapping at 128;
- a 13-bit fraction latch used later as a multiplier coefficient;
- a 12-bit address latch used later as an address offset;
- an effect-output write port, carrying the upper 16 bits of the scaled word and a selected slot index.

The fraction and address latches pick their source differently in the pass-through mode. In that mode the fraction latch takes raw low bits instead of a scaled slice. The address latch takes a slice of the scaled word instead of the upper byte of the input operand.

Each step is marked by `step_vld`. When `step_vld` is low, no state changes and every strobe stays low.

Top module: `dsp_shift_latch`

## Requirements
- R1: The scaled word in a step is derived from the accumulator presented in the most recent earlier cycle with `step_vld`=1. The held accumulator changes only on a clock edge with `step_vld`=1.
- R2: `shift_mode`=0: the 26-bit accumulator is clamped to the range -0x800000 to 0x7FFFFF.
- R3: `shift_mode`=1: the accumulator is doubled and then clamped to the same range.
- R4: `shift_mode`=2: the accumulator is doubled and the low 24 bits are kept, with no clamping.
- R5: `shift_mode`=3: the low 24 bits of the accumulator pass through unchanged.
- R6: When a step has `frc_ld`=1, `frac_q` loads on that edge. In mode 3 it loads the scaled word's bits [11:0], zero-extended to 13 bits. In other modes it loads the scaled word arithmetically shifted right by 11, which is bits [23:11].
- R7: When a step has `adr_ld`=1, `adr_q` loads on that edge. In mode 3 it loads the scaled word's bits [23:12]. In other modes it loads `opnd_in` bits [23:16], sign-extended to 12 bits.
- R8: A step with `eff_wr`=1 raises `eff_we` in that cycle. `eff_idx` equals `eff_sel`, and `eff_dat` carries the scaled word's bits [23:8].
- R9: A step with `tmp_wr`=1 raises `tmp_we` in that cycle. `tmp_addr` is (`tmp_ofs` + `ring_ct`) mod 128, and `tmp_dat` carries the scaled word.
- R10: With `step_vld`=0, or with a latch's flag low, that latch holds its value. Both write strobes are low whenever `step_vld`=0.
- R11: After reset the held accumulator, `frac_q` and `adr_q` are zero, so `shifted` reads 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_vld | input | 1 | One processing step occurs this cycle |
| acc_in | input | 26 | Signed accumulator result of this step |
| shift_mode | input | 2 | Scaling mode 0..3 |
| opnd_in | input | 24 | Signed selected input operand |
| frc_ld | input | 1 | Load fraction latch |
| adr_ld | input | 1 | Load address latch |
| eff_wr | input | 1 | Write effect output |
| eff_sel | input | 4 | Effect slot index |
| tmp_wr | input | 1 | Write temporary RAM |
| tmp_ofs | input | 7 | Temporary RAM offset |
| ring_ct | input | 7 | Ring counter |
| shifted | output | 24 | Scaled word |
| frac_q | output | 13 | Fraction latch |
| adr_q | output | 12 | Address latch |
| eff_we | output | 1 | Effect write strobe |
| eff_idx | output | 4 | Effect slot index |
| eff_dat | output | 16 | Effect write data |
| tmp_we | output | 1 | Temporary RAM write strobe |
| tmp_addr | output | 7 | Temporary RAM address |
| tmp_dat | output | 24 | Temporary RAM write data |

## Verification
The fraction latch and the address latch can both load in the same step. In mode 3 both draw on the same scaled word. In the other modes one draws on the scaled word and the other on the input operand.

The bench drives steps with both flags set across all four modes. It uses accumulators just past the clamp limits and operands with the sign bit set. Each cycle it compares both latches, the scaled word and both write ports against an integer model that applies the mode rules to the accumulator of the previous step.

// File: rtl/dsp_shl_pkg.sv
package dsp_shl_pkg;
  typedef enum logic [1:0] {
    SH_SAT   = 2'd0,
    SH_DBLS  = 2'd1,
    SH_DBLW  = 2'd2,
    SH_PASS  = 2'd3
  } shift_mode_e;
endpackage

// File: rtl/dsp_rst_sync.sv
module dsp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dsp_acc_delay.sv
module dsp_acc_delay #(
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_vld,
  input  logic [ACC_W-1:0] acc_in,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (step_vld) acc_d = acc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assert_acc_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld |=> (acc_q == $past(acc_in)));
  assert_acc_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !step_vld |=> $stable(acc_q));
endmodule

// File: rtl/dsp_out_shifter.sv
module dsp_out_shifter
  import dsp_shl_pkg::*;
#(
  parameter int ACC_W = 26,
  parameter int OUT_W = 24
) (
  input  logic [ACC_W-1:0] acc_q,
  input  logic [1:0]       mode,
  output logic [OUT_W-1:0] sh
);
  localparam int XW = ACC_W + 1;
  localparam logic signed [XW-1:0] SAT_HI = {{(XW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [XW-1:0] SAT_LO = {{(XW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [XW-1:0] acc_x;
  logic signed [XW-1:0] acc_dbl;
  logic        [OUT_W-1:0] sat_src;
  logic signed [XW-1:0] sat_in;

  always_comb begin
    acc_x   = $signed({acc_q[ACC_W-1], acc_q});
    acc_dbl = $signed({acc_q, 1'b0});
    sat_in  = (mode == SH_DBLS) ? acc_dbl : acc_x;
    if (sat_in > SAT_HI)      sat_src = SAT_HI[OUT_W-1:0];
    else if (sat_in < SAT_LO) sat_src = SAT_LO[OUT_W-1:0];
    else                      sat_src = sat_in[OUT_W-1:0];
    case (shift_mode_e'(mode))
      SH_SAT, SH_DBLS: sh = sat_src;
      SH_DBLW:         sh = acc_dbl[OUT_W-1:0];
      default:         sh = acc_q[OUT_W-1:0];
    endcase
  end

  always_comb begin
    if (!$isunknown({acc_q, mode})) begin
      if (mode == 2'd0 && acc_x > SAT_HI)
        assert_sat_hi_R2: assert (sh == SAT_HI[OUT_W-1:0]);
      if (mode == 2'd1)
        assert_dbl_sign_R3: assert (sh[OUT_W-1] == acc_q[ACC_W-1]);
    end
  end
endmodule

// File: rtl/dsp_latch_regs.sv
module dsp_latch_regs
  import dsp_shl_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int FRC_W = OUT_W - 11,
  parameter int ADR_W = OUT_W - 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_vld,
  input  logic [1:0]       mode,
  input  logic [OUT_W-1:0] sh,
  input  logic [OUT_W-1:0] opnd,
  input  logic             frc_ld,
  input  logic             adr_ld,
  output logic [FRC_W-1:0] frac_q,
  output logic [ADR_W-1:0] adr_q
);
  localparam int OPH_W = OUT_W - 16;

  logic             frc_en, adr_en;
  logic [FRC_W-1:0] frac_d;
  logic [ADR_W-1:0] adr_d;

  assign frc_en = step_vld & frc_ld;
  assign adr_en = step_vld & adr_ld;

  always_comb begin
    frac_d = frac_q;
    adr_d  = adr_q;
    if (frc_en) begin
      if (mode == SH_PASS) frac_d = {{(FRC_W-12){1'b0}}, sh[11:0]};
      else                 frac_d = sh[OUT_W-1:11];
    end
    if (adr_en) begin
      if (mode == SH_PASS) adr_d = sh[OUT_W-1:12];
      else                 adr_d = {{(ADR_W-OPH_W){opnd[OUT_W-1]}}, opnd[OUT_W-1:16]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      adr_q  <= '0;
    end else begin
      frac_q <= frac_d;
      adr_q  <= adr_d;
    end
  end

  assert_frc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frc_en |=> $stable(frac_q));
  assert_adr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adr_en |=> $stable(adr_q));
  assert_adr_opnd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_en && mode != 2'd3) |=> (adr_q[OPH_W-1:0] == $past(opnd[OUT_W-1:16])));
endmodule

// File: rtl/dsp_write_ports.sv
module dsp_write_ports #(
  parameter int OUT_W  = 24,
  parameter int TMP_AW = 7,
  parameter int EFF_AW = 4,
  parameter int EFF_DW = OUT_W - 8
) (
  input  logic              step_vld,
  input  logic [OUT_W-1:0]  sh,
  input  logic              eff_wr,
  input  logic [EFF_AW-1:0] eff_sel,
  input  logic              tmp_wr,
  input  logic [TMP_AW-1:0] tmp_ofs,
  input  logic [TMP_AW-1:0] ring_ct,
  output logic              eff_we,
  output logic [EFF_AW-1:0] eff_idx,
  output logic [EFF_DW-1:0] eff_dat,
  output logic              tmp_we,
  output logic [TMP_AW-1:0] tmp_addr,
  output logic [OUT_W-1:0]  tmp_dat
);
  always_comb begin
    eff_we   = step_vld & eff_wr;
    eff_idx  = eff_sel;
    eff_dat  = sh[OUT_W-1:8];
    tmp_we   = step_vld & tmp_wr;
    tmp_addr = tmp_ofs + ring_ct;
    tmp_dat  = sh;
  end

  always_comb begin
    if (!step_vld && !$isunknown({eff_we, tmp_we}))
      assert_idle_strobes_R10: assert (!eff_we && !tmp_we);
  end
endmodule

// File: rtl/dsp_shift_latch.sv
module dsp_shift_latch #(
  parameter int ACC_W  = 26,
  parameter int OUT_W  = 24,
  parameter int TMP_AW = 7,
  parameter int EFF_AW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_vld,
  input  logic [ACC_W-1:0]    acc_in,
  input  logic [1:0]          shift_mode,
  input  logic [OUT_W-1:0]    opnd_in,
  input  logic                frc_ld,
  input  logic                adr_ld,
  input  logic                eff_wr,
  input  logic [EFF_AW-1:0]   eff_sel,
  input  logic                tmp_wr,
  input  logic [TMP_AW-1:0]   tmp_ofs,
  input  logic [TMP_AW-1:0]   ring_ct,
  output logic [OUT_W-1:0]    shifted,
  output logic [OUT_W-12:0]   frac_q,
  output logic [OUT_W-13:0]   adr_q,
  output logic                eff_we,
  output logic [EFF_AW-1:0]   eff_idx,
  output logic [OUT_W-9:0]    eff_dat,
  output logic                tmp_we,
  output logic [TMP_AW-1:0]   tmp_addr,
  output logic [OUT_W-1:0]    tmp_dat
);
  localparam int FRC_W  = OUT_W - 11;
  localparam int ADR_W  = OUT_W - 12;
  localparam int EFF_DW = OUT_W - 8;

  logic             rst_sync_n;
  logic [ACC_W-1:0] acc_q;
  logic [OUT_W-1:0] sh;

  dsp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dsp_acc_delay #(.ACC_W(ACC_W)) u_dly (
    .clk(clk), .rst_n(rst_sync_n), .step_vld(step_vld),
    .acc_in(acc_in), .acc_q(acc_q)
  );

  dsp_out_shifter #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_shf (
    .acc_q(acc_q), .mode(shift_mode), .sh(sh)
  );

  dsp_latch_regs #(.OUT_W(OUT_W), .FRC_W(FRC_W), .ADR_W(ADR_W)) u_lat (
    .clk(clk), .rst_n(rst_sync_n), .step_vld(step_vld), .mode(shift_mode),
    .sh(sh), .opnd(opnd_in), .frc_ld(frc_ld), .adr_ld(adr_ld),
    .frac_q(frac_q), .adr_q(adr_q)
  );

  dsp_write_ports #(.OUT_W(OUT_W), .TMP_AW(TMP_AW), .EFF_AW(EFF_AW), .EFF_DW(EFF_DW)) u_wr (
    .step_vld(step_vld), .sh(sh), .eff_wr(eff_wr), .eff_sel(eff_sel),
    .tmp_wr(tmp_wr), .tmp_ofs(tmp_ofs), .ring_ct(ring_ct),
    .eff_we(eff_we), .eff_idx(eff_idx), .eff_dat(eff_dat),
    .tmp_we(tmp_we), .tmp_addr(tmp_addr), .tmp_dat(tmp_dat)
  );

  assign shifted = sh;
endmodule

// File: tb/tb_dsp_shift_latch.sv
`timescale 1ns/1ps
module tb_dsp_shift_latch;
  logic clk = 1'b0;
  logic rst_n;
  logic step_vld;
  logic [25:0] acc_in;
  logic [1:0]  shift_mode;
  logic [23:0] opnd_in;
  logic frc_ld, adr_ld, eff_wr, tmp_wr;
  logic [3:0] eff_sel;
  logic [6:0] tmp_ofs, ring_ct;
  logic [23:0] shifted;
  logic [12:0] frac_q;
  logic [11:0] adr_q;
  logic eff_we, tmp_we;
  logic [3:0] eff_idx;
  logic [15:0] eff_dat;
  logic [6:0] tmp_addr;
  logic [23:0] tmp_dat;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  longint m_acc;
  longint m_frc;
  longint m_adr;

  always #2.5 clk = ~clk;

  dsp_shift_latch dut (
    .clk(clk), .rst_n(rst_n), .step_vld(step_vld), .acc_in(acc_in),
    .shift_mode(shift_mode), .opnd_in(opnd_in), .frc_ld(frc_ld), .adr_ld(adr_ld),
    .eff_wr(eff_wr), .eff_sel(eff_sel), .tmp_wr(tmp_wr), .tmp_ofs(tmp_ofs),
    .ring_ct(ring_ct), .shifted(shifted), .frac_q(frac_q), .adr_q(adr_q),
    .eff_we(eff_we), .eff_idx(eff_idx), .eff_dat(eff_dat), .tmp_we(tmp_we),
    .tmp_addr(tmp_addr), .tmp_dat(tmp_dat)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint sx(input longint v, input int w);
    longint m;
    m = (longint'(1) << w) - 1;
    v = v & m;
    if (v[w-1]) return v - (longint'(1) << w);
    return v;
  endfunction

  function automatic longint clamp24(input longint v);
    if (v > 64'sh7FFFFF) return 64'sh7FFFFF;
    if (v < -64'sh800000) return -64'sh800000;
    return v;
  endfunction

  function automatic longint model_sh(input longint a, input int mode);
    case (mode)
      0: return clamp24(a) & 24'hFFFFFF;
      1: return clamp24(2 * a) & 24'hFFFFFF;
      2: return (2 * a) & 24'hFFFFFF;
      default: return a & 24'hFFFFFF;
    endcase
  endfunction

  task automatic step(input bit v, input longint acc, input int mode, input longint opnd,
                      input bit fl, input bit al, input bit ew, input bit tw,
                      input int es, input int to, input int rc);
    longint esh, ssh;
    @(negedge clk);
    step_vld = v; acc_in = acc[25:0]; shift_mode = mode[1:0]; opnd_in = opnd[23:0];
    frc_ld = fl; adr_ld = al; eff_wr = ew; tmp_wr = tw;
    eff_sel = es[3:0]; tmp_ofs = to[6:0]; ring_ct = rc[6:0];
    #1;
    esh = model_sh(m_acc, mode);
    ssh = sx(esh, 24);
    case (mode)
      0: chk("R1/R2 shifted", shifted, esh);
      1: chk("R1/R3 shifted", shifted, esh);
      2: chk("R1/R4 shifted", shifted, esh);
      default: chk("R1/R5 shifted", shifted, esh);
    endcase
    chk("R6/R10 frac_q", frac_q, m_frc);
    chk("R7/R10 adr_q", adr_q, m_adr);
    chk("R8/R10 eff_we", eff_we, v & ew);
    chk("R9/R10 tmp_we", tmp_we, v & tw);
    if (v & ew) begin
      chk("R8 eff_idx", eff_idx, es);
      chk("R8 eff_dat", eff_dat, (ssh >>> 8) & 16'hFFFF);
    end
    if (v & tw) begin
      chk("R9 tmp_addr", tmp_addr, (to + rc) & 127);
      chk("R9 tmp_dat", tmp_dat, esh);
    end
    if (v) begin
      m_acc = sx(acc, 26);
      if (fl) m_frc = (mode == 3) ? (esh & 12'hFFF) : ((ssh >>> 11) & 13'h1FFF);
      if (al) m_adr = (mode == 3) ? ((ssh >>> 12) & 12'hFFF)
                                  : ((sx(opnd, 24) >>> 16) & 12'hFFF);
    end
  endtask

  initial begin
    m_acc = 0; m_frc = 0; m_adr = 0;
    rst_n = 1'b0; step_vld = 0; acc_in = '0; shift_mode = '0; opnd_in = '0;
    frc_ld = 0; adr_ld = 0; eff_wr = 0; tmp_wr = 0; eff_sel = '0; tmp_ofs = '0; ring_ct = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 shifted", shifted, 0);
    chk("R11 frac_q", frac_q, 0);
    chk("R11 adr_q", adr_q, 0);
    chk("R11 eff_we", eff_we, 0);
    chk("R11 tmp_we", tmp_we, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int md = 0; md < 4; md++) step(0, 0, md, 0, 0, 0, 0, 0, 0, 0, 0);

    // Clamp and wrap corners; each value is loaded then viewed in all four modes
    // while both latches load in the same step (R6 and R7 together).
    begin
      longint corners[10];
      corners = '{64'sh7FFFFF, 64'sh800000, -64'sh800000, -64'sh800001,
                  64'sh3FFFFF, 64'sh400000, -64'sh400001, 64'sh1FFFFFF,
                  -64'sh2000000, 64'sh0ABCDE};
      foreach (corners[i]) begin
        for (int md = 0; md < 4; md++) begin
          step(1, corners[i], md, 64'h8F1234, 0, 0, 0, 0, 0, 0, 0);
          step(1, corners[i], md, 64'h8F1234, 1, 1, 1, 1, md + 3, 100, 60 + md);
        end
      end
    end

    // R10: idle steps with flags high change nothing
    step(1, 64'sh123456, 3, 64'h7F0000, 1, 1, 0, 0, 0, 0, 0);
    step(0, 64'sh654321, 0, 64'h800000, 1, 1, 1, 1, 5, 1, 2);
    step(0, 64'sh000001, 1, 64'h000000, 1, 1, 1, 1, 5, 1, 2);
    step(1, 64'sh000001, 3, 64'h000000, 0, 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 3000; k++) begin
      longint a;
      a = sx({$urandom, $urandom}, 26);
      if (k % 5 == 0) a = sx(64'sh7FFFF0 + $urandom_range(0, 32), 26);
      step($urandom_range(0, 3) != 0, a, $urandom_range(0, 3), $urandom,
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 127),
           $urandom_range(0, 127));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule